// File: doc/BRIEF.md
# SPI host FIFO register interface

This block is the register-side front end of an SPI master. Software writes bytes to be sent into a transmit queue and takes received bytes out of a receive queue, through a plain 32-bit read/write register port. The serial engine sits on the far side of both queues. It takes bytes from the transmit queue and returns the bytes it shifts in to the receive queue. The shifting logic itself is not part of this block.

Queue status is read from bit 31 of the data registers, so software needs no separate status register. Reading the transmit data register reports "full". Reading the receive data register reports "empty", or else returns one byte and removes it from the queue. Two watermark conditions, one per queue, can each be enabled onto a single interrupt line.

A chip-select idle-level register keeps only the bits of the chip-select lines that are built. Software can therefore find the number of lines by writing all ones and reading the value back.

Top module: `spi_host_regfile`

## Requirements
- R1: After reset both queues are empty, the enable register (0x70), both mark registers (0x50, 0x54) and the pending register (0x74) read 0, the idle-level register (0x14) reads all ones in its CS_LINES implemented bits, and `irq` is low.
- R2: A write to offset 0x48 places `wdata[7:0]` at the tail of the transmit queue, and the engine side (`tx_valid`, `tx_data`, `tx_pop`) delivers the bytes in write order.
- R3: A read of 0x48 returns 0x8000_0000 when the transmit queue holds DEPTH entries, and 0 otherwise.
- R4: A write to 0x48 while the transmit queue is full is dropped: the count and the queued bytes stay unchanged.
- R5: A read of 0x4C while the receive queue is not empty returns the oldest byte in bits 7:0 with bit 31 clear, and removes that byte.
- R6: A read of 0x4C while the receive queue is empty returns 0x8000_0000 and leaves the queue unchanged.
- R7: Pending bit 0 is 1 exactly when the transmit count is strictly less than the value in 0x50.
- R8: Pending bit 1 is 1 exactly when the receive count is strictly greater than the value in 0x54.
- R9: `irq` is high exactly when some bit of the pending register is set and the same bit of the enable register (0x70) is set.
- R10: A write to 0x14 stores only bits CS_LINES-1:0. The higher bits always read 0, and the stored bits drive `cs_idle`.
- R11: The pending register is read-only: writes to 0x74 change nothing.
- R12: While the receive queue holds DEPTH entries, `rx_ready` is low and an `rx_push` is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops receive data) |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the same cycle as reg_rd |
| tx_valid | output | 1 | Transmit queue holds a byte |
| tx_data | output | 8 | Oldest transmit byte |
| tx_pop | input | 1 | Engine takes the oldest transmit byte |
| rx_push | input | 1 | Engine delivers a received byte |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Receive queue has room |
| cs_idle | output | CS_LINES | Idle level of each chip-select line |
| irq | output | 1 | Interrupt request |

## Verification
A receive count that has gone wrong shows up within one register read. Either a byte comes back out of order, or the empty flag in bit 31 disagrees with the number of bytes the bench has delivered. A transmit pointer or count that has slipped shows up as a wrong byte, or a wrong number of bytes, when the bench drains the queue through the engine port. It also shows up as bit 31 of 0x48 being set a write too early or too late. Watermark and enable faults are visible on `irq`, and in the pending read, in the cycle after the write that moves a count across a mark.

// File: rtl/spi_hfifo_pkg.sv
// Package: register offsets and bit positions shared by the register front end.
// Assumes byte offsets on an 8-bit address; software decodes these values.
package spi_hfifo_pkg;
    localparam int REG_AW = 8;
    localparam int REG_DW = 32;

    localparam logic [REG_AW-1:0] OFS_CS_IDLE = 8'h14;
    localparam logic [REG_AW-1:0] OFS_TX_DATA = 8'h48;
    localparam logic [REG_AW-1:0] OFS_RX_DATA = 8'h4C;
    localparam logic [REG_AW-1:0] OFS_TX_MARK = 8'h50;
    localparam logic [REG_AW-1:0] OFS_RX_MARK = 8'h54;
    localparam logic [REG_AW-1:0] OFS_IRQ_EN  = 8'h70;
    localparam logic [REG_AW-1:0] OFS_IRQ_PND = 8'h74;

    localparam int FLAG_BIT = 31;
    localparam int IRQ_TX   = 0;
    localparam int IRQ_RX   = 1;
    localparam int IRQ_N    = 2;
endpackage

// File: rtl/spi_hfifo_queue.sv
// Module: synchronous first-in first-out queue with occupancy count.
// Assumes push and pop in the same cycle are legal. A push while full and a
// pop while empty are ignored.
module spi_hfifo_queue #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);
    logic [WIDTH-1:0] store [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = store[rd_ptr];

    function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Purpose: write an accepted entry into storage.
    always_ff @(posedge clk) begin
        if (do_push) store[wr_ptr] <= push_data;
    end

    // Purpose: advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= next_ptr(wr_ptr);
            if (do_pop)  rd_ptr <= next_ptr(rd_ptr);
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
    assert_drop_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> $stable(count));
    assert_empty_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> $stable(count));
endmodule

// File: rtl/spi_hfifo_irq.sv
// Module: watermark comparison and interrupt gating.
// Assumes counts and marks share one width. The pending bits are live
// conditions, not latched events.
module spi_hfifo_irq #(
    parameter int CNT_W = 4,
    localparam int IRQ_N = spi_hfifo_pkg::IRQ_N
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] tx_count,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] tx_mark,
    input  logic [CNT_W-1:0] rx_mark,
    input  logic [IRQ_N-1:0] irq_en,
    output logic [IRQ_N-1:0] irq_pnd,
    output logic             irq
);
    import spi_hfifo_pkg::*;

    // Purpose: form the live watermark conditions.
    always_comb begin
        irq_pnd         = '0;
        irq_pnd[IRQ_TX] = (tx_count < tx_mark);
        irq_pnd[IRQ_RX] = (rx_count > rx_mark);
    end

    assign irq = |(irq_pnd & irq_en);

    assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en == '0) |-> !irq);
    assert_tx_empty_mark_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count == '0 && tx_mark != '0) |-> irq_pnd[IRQ_TX]);
endmodule

// File: rtl/spi_host_regfile.sv
// Module: register front end of an SPI master. It holds the transmit and
// receive queues, the watermark interrupt and the chip-select idle levels.
// Assumes a single-cycle register port: read data is combinational in the
// cycle of reg_rd, and a read of the receive data register pops at that edge.
module spi_host_regfile #(
    parameter int DEPTH    = 8,
    parameter int DATA_W   = 8,
    parameter int CS_LINES = 4,
    localparam int CNT_W   = $clog2(DEPTH + 1),
    localparam int AW      = spi_hfifo_pkg::REG_AW,
    localparam int DW      = spi_hfifo_pkg::REG_DW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [AW-1:0]       reg_addr,
    input  logic [DW-1:0]       reg_wdata,
    output logic [DW-1:0]       reg_rdata,
    output logic                tx_valid,
    output logic [DATA_W-1:0]   tx_data,
    input  logic                tx_pop,
    input  logic                rx_push,
    input  logic [DATA_W-1:0]   rx_data,
    output logic                rx_ready,
    output logic [CS_LINES-1:0] cs_idle,
    output logic                irq
);
    import spi_hfifo_pkg::*;

    logic [CNT_W-1:0]  tx_count, rx_count, tx_mark, rx_mark;
    logic              tx_full, tx_empty, rx_full, rx_empty;
    logic [DATA_W-1:0] rx_head;
    logic [IRQ_N-1:0]  irq_en, irq_pnd;
    logic              tx_wr, rx_rd;

    assign tx_wr = reg_wr && (reg_addr == OFS_TX_DATA);
    assign rx_rd = reg_rd && (reg_addr == OFS_RX_DATA);

    spi_hfifo_queue #(.DEPTH(DEPTH), .WIDTH(DATA_W)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .push(tx_wr), .push_data(reg_wdata[DATA_W-1:0]),
        .pop(tx_pop), .head(tx_data), .count(tx_count),
        .full(tx_full), .empty(tx_empty)
    );

    spi_hfifo_queue #(.DEPTH(DEPTH), .WIDTH(DATA_W)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .push(rx_push), .push_data(rx_data),
        .pop(rx_rd), .head(rx_head), .count(rx_count),
        .full(rx_full), .empty(rx_empty)
    );

    assign tx_valid = !tx_empty;
    assign rx_ready = !rx_full;

    spi_hfifo_irq #(.CNT_W(CNT_W)) u_irq (
        .clk(clk), .rst_n(rst_n),
        .tx_count(tx_count), .rx_count(rx_count),
        .tx_mark(tx_mark), .rx_mark(rx_mark),
        .irq_en(irq_en), .irq_pnd(irq_pnd), .irq(irq)
    );

    // Purpose: hold the writable control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_mark <= '0;
            rx_mark <= '0;
            irq_en  <= '0;
            cs_idle <= '1;
        end else if (reg_wr) begin
            case (reg_addr)
                OFS_TX_MARK: tx_mark <= reg_wdata[CNT_W-1:0];
                OFS_RX_MARK: rx_mark <= reg_wdata[CNT_W-1:0];
                OFS_IRQ_EN:  irq_en  <= reg_wdata[IRQ_N-1:0];
                OFS_CS_IDLE: cs_idle <= reg_wdata[CS_LINES-1:0];
                default: ;
            endcase
        end
    end

    // Purpose: select read data and status flags for the addressed register.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_TX_DATA: reg_rdata[FLAG_BIT] = tx_full;
            OFS_RX_DATA: begin
                if (rx_empty) reg_rdata[FLAG_BIT] = 1'b1;
                else          reg_rdata = DW'(rx_head);
            end
            OFS_TX_MARK: reg_rdata = DW'(tx_mark);
            OFS_RX_MARK: reg_rdata = DW'(rx_mark);
            OFS_IRQ_EN:  reg_rdata = DW'(irq_en);
            OFS_IRQ_PND: reg_rdata = DW'(irq_pnd);
            OFS_CS_IDLE: reg_rdata = DW'(cs_idle);
            default:     reg_rdata = '0;
        endcase
    end

    assert_rx_empty_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd && rx_empty && !rx_push) |=> rx_empty);
    assert_rx_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd && !rx_empty && !rx_push) |=> (rx_count == $past(rx_count) - 1'b1));
    assert_tx_full_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr && tx_full && !tx_pop) |=> tx_full);
    assert_rx_ready_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && !rx_ready && !rx_rd) |=> !rx_ready);
endmodule

// File: tb/test_spi_host_regfile.sv
module test_spi_host_regfile;
    localparam int DEPTH = 8;
    localparam int CSN   = 4;

    logic        clk = 0, rst_n = 0;
    logic        reg_wr = 0, reg_rd = 0;
    logic [7:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic        tx_valid, tx_pop = 0, rx_push = 0, rx_ready, irq;
    logic [7:0]  tx_data, rx_data = 0;
    logic [CSN-1:0] cs_idle;

    int n_chk = 0, n_err = 0, n_popped = 0;
    logic [7:0] exp_tx[$];
    logic [7:0] exp_rx[$];

    always #4 clk = ~clk;

    spi_host_regfile #(.DEPTH(DEPTH), .DATA_W(8), .CS_LINES(CSN)) i_spi_host_regfile (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_data(rx_data), .rx_ready(rx_ready),
        .cs_idle(cs_idle), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); reg_rd = 1; reg_addr = a; #1 d = reg_rdata;
        @(negedge clk); reg_rd = 0;
    endtask

    // Driver: write a transmit byte, expecting it only if the queue has room.
    task automatic drv_tx(input logic [7:0] b);
        logic [31:0] st;
        rd(8'h48, st);
        if (!st[31]) exp_tx.push_back(b);
        wr(8'h48, {24'h0, b});
    endtask

    // Driver: deliver a receive byte from the engine side.
    task automatic drv_rx(input logic [7:0] b);
        @(negedge clk); rx_push = 1; rx_data = b;
        if (rx_ready) exp_rx.push_back(b);
        @(negedge clk); rx_push = 0;
    endtask

    // Monitor for the engine side: compares each byte taken against the queue.
    always @(negedge clk) begin
        #1;
        if (rst_n && tx_pop && tx_valid) begin
            n_popped++;
            if (exp_tx.size() == 0) chk("R2 unexpected tx byte", {24'h0, tx_data}, 32'hxx);
            else chk("R2 tx order", {24'h0, tx_data}, {24'h0, exp_tx.pop_front()});
        end
    end

    task automatic drain_tx();
        @(negedge clk); tx_pop = 1;
        forever begin
            @(negedge clk); #2;
            if (!tx_valid) break;
        end
        tx_pop = 0;
    endtask

    // Monitor for register reads of receive data.
    task automatic read_rx_expect(input string req);
        logic [31:0] d;
        rd(8'h4C, d);
        if (exp_rx.size() == 0) chk(req, d, 32'h8000_0000);
        else chk(req, d, {24'h0, exp_rx.pop_front()});
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        repeat (4) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        rd(8'h70, d); chk("R1 enable", d, 0);
        rd(8'h50, d); chk("R1 tx mark", d, 0);
        rd(8'h54, d); chk("R1 rx mark", d, 0);
        rd(8'h74, d); chk("R1 pending", d, 0);
        rd(8'h14, d); chk("R1 cs idle", d, 32'hF);
        chk("R1 irq", {31'h0, irq}, 0);
        chk("R1 tx_valid", {31'h0, tx_valid}, 0);

        // R10 chip-select idle width discovery
        wr(8'h14, 32'hFFFF_FFFF); rd(8'h14, d); chk("R10 all ones", d, 32'hF);
        wr(8'h14, 32'hA5A5_A5A5); rd(8'h14, d); chk("R10 partial", d, 32'h5);
        chk("R10 cs_idle pin", {28'h0, cs_idle}, 32'h5);

        // R2, R3, R4 transmit queue
        drv_tx(8'h11); drv_tx(8'h22); drv_tx(8'h33);
        rd(8'h48, d); chk("R3 not full", d, 0);
        for (int i = 0; i < 5; i++) drv_tx(8'h40 + 8'(i));
        rd(8'h48, d); chk("R3 full flag", d, 32'h8000_0000);
        wr(8'h48, 32'h99);
        rd(8'h48, d); chk("R4 still full", d, 32'h8000_0000);
        n_popped = 0;
        drain_tx();
        chk("R4 byte count after drop", n_popped, DEPTH);
        chk("R2 scoreboard empty", exp_tx.size(), 0);

        // R7 transmit watermark
        wr(8'h50, 2);
        rd(8'h74, d); chk("R7 below mark", d & 1, 1);
        drv_tx(8'hC1); drv_tx(8'hC2);
        rd(8'h74, d); chk("R7 at mark", d & 1, 0);

        // R9 interrupt gating
        wr(8'h50, 3);
        chk("R9 disabled", {31'h0, irq}, 0);
        wr(8'h70, 1);
        chk("R9 tx enabled", {31'h0, irq}, 1);
        wr(8'h70, 2);
        chk("R9 other bit enabled", {31'h0, irq}, 0);
        wr(8'h70, 0);
        drain_tx();

        // R6 empty read then normal data
        read_rx_expect("R6 empty read");
        drv_rx(8'h5A);
        read_rx_expect("R6 no state change then R5 data");

        // R8 receive watermark
        wr(8'h54, 1);
        drv_rx(8'h01);
        rd(8'h74, d); chk("R8 at mark", d & 2, 0);
        drv_rx(8'h02);
        rd(8'h74, d); chk("R8 above mark", d & 2, 2);
        wr(8'h70, 2);
        chk("R9 rx enabled", {31'h0, irq}, 1);

        // R11 pending register read-only
        wr(8'h74, 0);
        rd(8'h74, d); chk("R11 write ignored", d & 2, 2);

        // R5 ordered reads
        read_rx_expect("R5 first");
        read_rx_expect("R5 second");
        chk("R9 rx cleared", {31'h0, irq}, 0);

        // R12 receive overflow
        for (int i = 0; i < DEPTH; i++) drv_rx(8'h80 + 8'(i));
        chk("R12 rx_ready low", {31'h0, rx_ready}, 0);
        drv_rx(8'hEE);
        for (int i = 0; i < DEPTH; i++) read_rx_expect("R12 retained data");
        read_rx_expect("R12 empty after drop");

        finish_run();
    end
endmodule